// File: doc/BRIEF.md
# Slice Error Status and Interrupt Register

This block is a single 64-bit status word for one processing slice. Hardware error events set sticky flags in the word, and each flag stays set until software writes a one to its position. The same word holds a 16-bit interrupt source number that software reads and writes directly. While any flag is set, the block raises an interrupt request and presents that source number with it.

A context-save watchdog is built in. When a save request goes to the attached accelerator, a counter loads a programmable interval and counts down. If the acknowledge has not arrived when the counter reaches zero, a warning flag in the status word is set. Software accesses the word over a simple privileged register bus. Only full 64-bit accesses take effect. A build parameter can remove the register, and it then reads as zero.

Bits are numbered big-endian: bit 0 is the most significant bit and sits at vector index 63, so bit n sits at index 63-n.

Top module: `slice_err_reg`

## Requirements
- R1: After synchronous reset, every status flag, the interrupt number and the watchdog are zero, and a privileged full read returns 0.
- R2: Bits 48..63 (vector [15:0]) hold the interrupt number, which is read/write. After a write of 0x000000000000FFFF, a read returns 0x000000000000FFFF, and `irq_src` always shows the stored number.
- R3: `impl_err_in[45:16]` set bits 0..29 (vector [63:34]), and `impl_err_in[15:0]` set bits 32..47 (vector [31:16]). Each flag stays 1 after its input drops.
- R4: `acc_err_in` sets bit 30 (vector [33]), and that flag stays 1.
- R5: A privileged full write clears every status flag written as 1 and leaves every flag written as 0 unchanged.
- R6: If a set event and a write-one-to-clear hit the same flag in the same cycle, the flag ends up 1.
- R7: `irq_req` is 1 exactly when at least one status flag (vector [63:16]) is 1.
- R8: A write with `bus_priv`=0 or `bus_full`=0 changes nothing.
- R9: A read with `bus_priv`=0 or `bus_full`=0 returns zero. `bus_rdata` is zero whenever no valid read is present.
- R10: A `save_req` sampled at clock edge k with `warn_interval`=N sets bit 31 (vector [32]) at edge k+N+1, provided no `save_ack` arrives. The flag is set only once per request.
- R11: A `save_ack` sampled while the countdown runs stops it, and bit 31 is not set for that request.
- R12: With `ENABLE`=0, `bus_rdata`, `irq_req` and `irq_src` stay zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_valid | input | 1 | Register access present this cycle |
| bus_write | input | 1 | 1 = write, 0 = read |
| bus_priv | input | 1 | Access carries privilege |
| bus_full | input | 1 | Access is one full 64-bit operation |
| bus_wdata | input | 64 | Write data |
| bus_rdata | output | 64 | Read data (combinational) |
| impl_err_in | input | 46 | Implementation-defined error events |
| acc_err_in | input | 1 | Accelerator error event |
| save_req | input | 1 | Context-save request issued |
| save_ack | input | 1 | Accelerator acknowledged the save |
| warn_interval | input | CNT_W | Watchdog interval in cycles |
| irq_req | output | 1 | Error interrupt request |
| irq_src | output | 16 | Interrupt source number |

## Verification
A wrong flag bit shows up on the next privileged read and in `irq_req` one cycle after the event edge. A lost or doubled clear shows up on the read that follows the write. A watchdog that is off by one cycle shows the warning flag on the wrong side of edge k+N+1. The bench reads exactly one cycle before and one cycle after that edge, so the error is caught at once. If privilege or width gating leaks, the stored interrupt number or the read data changes, and the next access exposes it.

// File: rtl/slice_err_pkg.sv
package slice_err_pkg;
    localparam int WORD_W = 64;
    localparam int IVN_W  = 16;
    localparam int STAT_W = WORD_W - IVN_W;
    localparam int IMPL_W = STAT_W - 2;
    localparam int HI_W   = 30;
    localparam int LO_W   = IMPL_W - HI_W;
    localparam int IDX_AE = LO_W + 1;
    localparam int IDX_HC = LO_W;

    typedef struct packed {
        logic              wr_en;
        logic              rd_en;
        logic [WORD_W-1:0] wdata;
    } bus_cmd_t;

    typedef enum logic {WD_IDLE = 1'b0, WD_RUN = 1'b1} wd_state_e;

    function automatic logic [STAT_W-1:0] pack_set(
        input logic [IMPL_W-1:0] impl, input logic ae, input logic hc);
        return {impl[IMPL_W-1:LO_W], ae, hc, impl[LO_W-1:0]};
    endfunction
endpackage

// File: rtl/slice_err_access.sv
module slice_err_access
    import slice_err_pkg::*;
#(
    parameter bit ENABLE = 1'b1
) (
    input  logic              bus_valid,
    input  logic              bus_write,
    input  logic              bus_priv,
    input  logic              bus_full,
    input  logic [WORD_W-1:0] bus_wdata,
    output bus_cmd_t          cmd
);
    logic granted;

    always_comb begin
        granted   = ENABLE && bus_valid && bus_priv && bus_full;
        cmd.wr_en = granted && bus_write;
        cmd.rd_en = granted && !bus_write;
        cmd.wdata = bus_wdata;
    end
endmodule

// File: rtl/slice_err_status.sv
module slice_err_status
    import slice_err_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic [STAT_W-1:0] set_vec,
    input  logic [STAT_W-1:0] clr_vec,
    output logic [STAT_W-1:0] stat_q
);
    for (genvar i = 0; i < STAT_W; i++) begin : g_flag
        always_ff @(posedge clk) begin
            if (rst)
                stat_q[i] <= 1'b0;
            else if (set_vec[i])
                stat_q[i] <= 1'b1;
            else if (clr_vec[i])
                stat_q[i] <= 1'b0;
        end
    end
endmodule

// File: rtl/slice_err_watchdog.sv
module slice_err_watchdog
    import slice_err_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start,
    input  logic             ack,
    input  logic [CNT_W-1:0] interval,
    output logic             expire
);
    wd_state_e        state_q;
    logic [CNT_W-1:0] cnt_q;

    assign expire = (state_q == WD_RUN) && !ack && (cnt_q == '0);

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= WD_IDLE;
            cnt_q   <= '0;
        end else if (start) begin
            state_q <= WD_RUN;
            cnt_q   <= interval;
        end else if (state_q == WD_RUN) begin
            if (ack || cnt_q == '0)
                state_q <= WD_IDLE;
            else
                cnt_q <= cnt_q - 1'b1;
        end
    end
endmodule

// File: rtl/slice_err_reg.sv
module slice_err_reg
    import slice_err_pkg::*;
#(
    parameter bit ENABLE = 1'b1,
    parameter int CNT_W  = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              bus_valid,
    input  logic              bus_write,
    input  logic              bus_priv,
    input  logic              bus_full,
    input  logic [WORD_W-1:0] bus_wdata,
    output logic [WORD_W-1:0] bus_rdata,
    input  logic [IMPL_W-1:0] impl_err_in,
    input  logic              acc_err_in,
    input  logic              save_req,
    input  logic              save_ack,
    input  logic [CNT_W-1:0]  warn_interval,
    output logic              irq_req,
    output logic [IVN_W-1:0]  irq_src
);
    bus_cmd_t          cmd;
    logic [STAT_W-1:0] set_vec;
    logic [STAT_W-1:0] clr_vec;
    logic [STAT_W-1:0] stat_q;
    logic [IVN_W-1:0]  ivn_q;
    logic              hc_set;
    logic              wd_start;

    slice_err_access #(.ENABLE(ENABLE)) u_access (
        .bus_valid (bus_valid),
        .bus_write (bus_write),
        .bus_priv  (bus_priv),
        .bus_full  (bus_full),
        .bus_wdata (bus_wdata),
        .cmd       (cmd)
    );

    assign wd_start = ENABLE && save_req;

    slice_err_watchdog #(.CNT_W(CNT_W)) u_wd (
        .clk      (clk),
        .rst      (rst),
        .start    (wd_start),
        .ack      (save_ack),
        .interval (warn_interval),
        .expire   (hc_set)
    );

    if (ENABLE) begin : g_on
        assign set_vec = pack_set(impl_err_in, acc_err_in, hc_set);
    end else begin : g_off
        assign set_vec = '0;
    end

    assign clr_vec = cmd.wr_en ? cmd.wdata[WORD_W-1:IVN_W] : '0;

    slice_err_status u_status (
        .clk     (clk),
        .rst     (rst),
        .set_vec (set_vec),
        .clr_vec (clr_vec),
        .stat_q  (stat_q)
    );

    always_ff @(posedge clk) begin
        if (rst)
            ivn_q <= '0;
        else if (cmd.wr_en)
            ivn_q <= cmd.wdata[IVN_W-1:0];
    end

    assign bus_rdata = cmd.rd_en ? {stat_q, ivn_q} : '0;
    assign irq_req   = |stat_q;
    assign irq_src   = ivn_q;
endmodule

// File: rtl/slice_err_reg_chk.sv
module slice_err_reg_chk
    import slice_err_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              bus_valid,
    input logic              bus_write,
    input logic              bus_priv,
    input logic              bus_full,
    input logic [WORD_W-1:0] bus_rdata,
    input logic              wr_en,
    input logic [WORD_W-1:0] wdata,
    input logic [STAT_W-1:0] set_vec,
    input logic [STAT_W-1:0] stat_q,
    input logic [IVN_W-1:0]  ivn_q,
    input logic              hc_set,
    input logic              irq_req
);
    assert_w1c_clears_R5: assert property (@(posedge clk) disable iff (rst)
        $past(!rst && wr_en && wdata[IVN_W+IDX_AE] && !set_vec[IDX_AE])
            |-> !stat_q[IDX_AE]);

    assert_set_wins_R6: assert property (@(posedge clk) disable iff (rst)
        $past(!rst && set_vec[IDX_AE]) |-> stat_q[IDX_AE]);

    assert_ivn_holds_R2: assert property (@(posedge clk) disable iff (rst)
        $past(!rst && !wr_en) |-> ivn_q == $past(ivn_q));

    assert_gated_write_R8: assert property (@(posedge clk) disable iff (rst)
        $past(!rst && bus_valid && bus_write && (!bus_priv || !bus_full))
            |-> (ivn_q == $past(ivn_q)));

    assert_gated_read_R9: assert property (@(posedge clk) disable iff (rst)
        (!bus_valid || bus_write || !bus_priv || !bus_full) |-> bus_rdata == '0);

    assert_irq_quiet_R7: assert property (@(posedge clk) disable iff (rst)
        $past(!rst && stat_q == '0 && set_vec == '0) |-> !irq_req);

    assert_hc_source_R10: assert property (@(posedge clk) disable iff (rst)
        ($past(!rst) && $rose(stat_q[IDX_HC])) |-> $past(hc_set));
endmodule

bind slice_err_reg slice_err_reg_chk u_chk (
    .clk       (clk),
    .rst       (rst),
    .bus_valid (bus_valid),
    .bus_write (bus_write),
    .bus_priv  (bus_priv),
    .bus_full  (bus_full),
    .bus_rdata (bus_rdata),
    .wr_en     (cmd.wr_en),
    .wdata     (cmd.wdata),
    .set_vec   (set_vec),
    .stat_q    (stat_q),
    .ivn_q     (ivn_q),
    .hc_set    (hc_set),
    .irq_req   (irq_req)
);

// File: tb/slice_err_reg_bench.sv
module slice_err_reg_bench;
    timeunit 1ns;
    timeprecision 100ps;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        bus_valid = 1'b0, bus_write = 1'b0, bus_priv = 1'b1, bus_full = 1'b1;
    logic [63:0] bus_wdata = '0;
    logic [63:0] bus_rdata, off_rdata;
    logic [45:0] impl_err_in = '0;
    logic        acc_err_in = 1'b0, save_req = 1'b0, save_ack = 1'b0;
    logic [15:0] warn_interval = '0;
    logic        irq_req, off_irq;
    logic [15:0] irq_src, off_src;

    always #2 clk = ~clk;

    slice_err_reg u_slice_err_reg (
        .clk(clk), .rst(rst), .bus_valid(bus_valid), .bus_write(bus_write),
        .bus_priv(bus_priv), .bus_full(bus_full), .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata), .impl_err_in(impl_err_in), .acc_err_in(acc_err_in),
        .save_req(save_req), .save_ack(save_ack), .warn_interval(warn_interval),
        .irq_req(irq_req), .irq_src(irq_src));

    slice_err_reg #(.ENABLE(1'b0)) u_slice_err_reg_off (
        .clk(clk), .rst(rst), .bus_valid(bus_valid), .bus_write(bus_write),
        .bus_priv(bus_priv), .bus_full(bus_full), .bus_wdata(bus_wdata),
        .bus_rdata(off_rdata), .impl_err_in(impl_err_in), .acc_err_in(acc_err_in),
        .save_req(save_req), .save_ack(save_ack), .warn_interval(warn_interval),
        .irq_req(off_irq), .irq_src(off_src));

    typedef struct {
        logic [63:0] exp;
        string       req;
    } exp_t;

    exp_t q[$];
    event ev_rd;
    int   n_cmp = 0;
    int   n_bad = 0;

    localparam logic [63:0] B_AE = 64'd1 << 33;
    localparam logic [63:0] B_HC = 64'd1 << 32;

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    initial forever begin
        exp_t e;
        @(ev_rd);
        #0.3;
        if (q.size() > 0) begin
            e = q.pop_front();
            chk(e.req, bus_rdata, e.exp);
        end
    end

    task automatic rd(input logic [63:0] exp, input string req,
                      input bit priv = 1'b1, input bit full = 1'b1);
        bus_valid = 1'b1; bus_write = 1'b0; bus_priv = priv; bus_full = full;
        q.push_back('{exp, req});
        ->ev_rd;
        #0.6;
        bus_valid = 1'b0; bus_priv = 1'b1; bus_full = 1'b1;
    endtask

    task automatic wr(input logic [63:0] d, input bit priv = 1'b1, input bit full = 1'b1);
        bus_valid = 1'b1; bus_write = 1'b1; bus_priv = priv; bus_full = full; bus_wdata = d;
        @(negedge clk);
        bus_valid = 1'b0; bus_write = 1'b0; bus_priv = 1'b1; bus_full = 1'b1;
    endtask

    task automatic off_check(input string req);
        bus_valid = 1'b1; bus_write = 1'b0;
        #0.3;
        chk(req, off_rdata, 64'd0);
        chk(req, {63'd0, off_irq}, 64'd0);
        chk(req, {48'd0, off_src}, 64'd0);
        bus_valid = 1'b0;
    endtask

    initial begin
        fork
            begin
                repeat (100000) @(posedge clk);
                n_bad++;
                $display("FAIL watchdog timeout actual=hung expected=done");
                $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
                $finish;
            end
        join_none
    end

    initial begin
        logic [63:0] w;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        // R1 reset state
        rd(64'd0, "R1 reset read");
        chk("R1 irq after reset", {63'd0, irq_req}, 64'd0);
        // R2 probe write
        wr(64'h0000_0000_0000_FFFF);
        w = 64'h0000_0000_0000_FFFF;
        rd(w, "R2 probe readback");
        chk("R2 irq_src", {48'd0, irq_src}, 64'hFFFF);
        chk("R7 no irq with no flags", {63'd0, irq_req}, 64'd0);
        // R3 implementation errors, both groups
        impl_err_in[45] = 1'b1; @(negedge clk); impl_err_in[45] = 1'b0;
        w |= 64'd1 << 63;
        rd(w, "R3 impl high group top");
        chk("R7 irq on flag", {63'd0, irq_req}, 64'd1);
        impl_err_in[0] = 1'b1; impl_err_in[16] = 1'b1; @(negedge clk); impl_err_in = '0;
        w |= (64'd1 << 16) | (64'd1 << 34);
        rd(w, "R3 impl boundary bits");
        // R4 accelerator error
        acc_err_in = 1'b1; @(negedge clk); acc_err_in = 1'b0;
        w |= B_AE;
        rd(w, "R4 AE set");
        off_check("R12 disabled instance");
        // R5 selective clear plus new number
        wr((64'd1 << 63) | (64'd1 << 16) | 64'h1234);
        w = (w & ~((64'd1 << 63) | (64'd1 << 16) | 64'hFFFF)) | 64'h1234;
        rd(w, "R5 selective w1c");
        chk("R2 irq_src update", {48'd0, irq_src}, 64'h1234);
        // R8 gated writes
        wr(64'hFFFF_FFFF_FFFF_0000, 1'b0, 1'b1);
        rd(w, "R8 unprivileged write ignored");
        wr(64'hFFFF_FFFF_FFFF_0000, 1'b1, 1'b0);
        rd(w, "R8 partial write ignored");
        // R9 gated reads
        rd(64'd0, "R9 unprivileged read", 1'b0, 1'b1);
        rd(64'd0, "R9 partial read", 1'b1, 1'b0);
        // R6 set beats clear
        acc_err_in = 1'b1;
        wr(B_AE | 64'h1234);
        acc_err_in = 1'b0;
        rd(w, "R6 set wins over clear");
        // clear everything
        wr(64'hFFFF_FFFF_FFFF_1234);
        w = 64'h1234;
        rd(w, "R5 clear all");
        chk("R7 irq drops", {63'd0, irq_req}, 64'd0);
        // R10 watchdog expiry timing
        warn_interval = 16'd5;
        save_req = 1'b1; @(negedge clk); save_req = 1'b0;
        repeat (5) @(negedge clk);
        rd(w, "R10 no HC at edge k+N");
        @(negedge clk);
        rd(w | B_HC, "R10 HC at edge k+N+1");
        chk("R7 irq on HC", {63'd0, irq_req}, 64'd1);
        wr(B_HC | 64'h1234);
        repeat (10) @(negedge clk);
        rd(w, "R10 HC fires once");
        // R11 acknowledge stops countdown
        save_req = 1'b1; @(negedge clk); save_req = 1'b0;
        @(negedge clk);
        save_ack = 1'b1; @(negedge clk); save_ack = 1'b0;
        repeat (12) @(negedge clk);
        rd(w, "R11 acked request no HC");
        off_check("R12 disabled after traffic");
        #1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule